// File: doc/BRIEF.md
# On-Die Termination Timing Controller

This block decides, one clock cycle at a time, whether the on-die termination of the DQ and DQS pins of a DDR memory interface is switched on. It watches read and write command strobes. After each read it opens a termination window that lines up with the returning read data. The window's start and end points are offsets in whole cycles. Each offset is built from two programmable fields plus a read round-trip alignment value, and the window's length also depends on the burst-length mode.

Writes open a shorter window. It covers the data burst plus a programmable tail. Because the pins drive the bus during the burst, that window only shows up in its tail. Whenever the pins are driving, termination is forced off. A static override keeps termination on for the whole of each read and whenever the bus is idle. The timing fields are captured when a command is accepted.

Top module: `odt_timing_ctrl`

## Requirements
- R1: After synchronous active-low reset, `odt_en` is low and no window is open, even when `bus_idle` is high with the override off.
- R2: Cycle k=0 is the first cycle after the clock edge that samples `rd_cmd`. The read window opens at k = E, where E = `rd_en_a` + `rd_en_b` + `rtt_align`.
- R3: The read window closes at k = F, so termination is on for E <= k < F. F = `rtt_align` + base + `rd_dis_a` + `rd_dis_b`, where base is 5 when `burst8`=0 and 7 when `burst8`=1. With all fields zero the window therefore lasts 5 or 7 cycles.
- R4: E and F are unsigned sums that do not overflow. Their maximums are E = 29 and F = 36.
- R5: Timing fields are sampled only with a command. Changing them while a window is running has no effect on that window.
- R6: A read accepted while the read window is on keeps `odt_en` on without a gap. The new window closes at the new command's F.
- R7: A write opens a window for k from 0 to base + `wr_dis` - 1, using the same base as reads.
- R8: `odt_en` is low in every cycle in which `pins_driving` is high. With `wr_dis` = 0 and the pins driving for the burst, a write shows no termination.
- R9: With `override_en` high, `odt_en` is high from k = 0 until k = F - 1 of each read, and in every cycle in which `bus_idle` is high, unless the pins are driving.
- R10: When E >= F, the read produces no timed termination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_cmd | input | 1 | Read command strobe, one cycle |
| wr_cmd | input | 1 | Write command strobe, one cycle |
| burst8 | input | 1 | 1 = burst length 8, 0 = burst length 4 |
| bus_idle | input | 1 | Bus has no transfer in progress |
| pins_driving | input | 1 | DQ/DQS output drivers are enabled |
| override_en | input | 1 | Static termination override |
| rd_en_a | input | 3 | Read enable offset, first field |
| rd_en_b | input | 3 | Read enable offset, second field |
| rd_dis_a | input | 3 | Read disable offset, first field |
| rd_dis_b | input | 3 | Read disable offset, second field |
| rtt_align | input | 4 | Read round-trip alignment, in cycles |
| wr_dis | input | 3 | Termination tail after write data, in cycles |
| odt_en | output | 1 | Termination enable for DQ/DQS |

## Verification
The bench drives each command at a falling edge, so the rising edge that follows loads the window counter. From that edge, `odt_en` for offset k is valid during cycle k, because only a combinational gate sits between the counter registers and the output. The bench therefore samples 5 ns after each following falling edge and compares against E <= k < F computed from the values it applied. It keeps comparing through k = F + 1 to confirm the window has closed. The pin-driving gate and the override act within the same cycle, so they are checked in the cycle where the stimulus is applied.

// File: rtl/odt_pkg.sv
// Shared parameters and helpers for the termination timing controller.
// Assumes offset fields are unsigned whole-cycle counts.
package odt_pkg;
    localparam int FLD_W_DEF   = 3;
    localparam int RTT_W_DEF   = 4;
    localparam int BL4_CYC_DEF = 5;
    localparam int BL8_CYC_DEF = 7;

    // Largest far-edge offset for the given field widths and burst base
    function automatic int max_off(input int fld_w, input int rtt_w, input int bl8);
        return (2 ** rtt_w - 1) + bl8 + 2 * (2 ** fld_w - 1);
    endfunction

    // Counter width able to hold the value n
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/odt_read_win.sv
// Read termination window: captures the near and far offsets when a read
// is accepted, then counts cycles k = 0.. and reports when E <= k < F.
// A read that arrives while the window is on sets a hold flag, so the
// output stays on until the new window closes. Assumes BL8_CYC >= 1.
module odt_read_win
    import odt_pkg::*;
#(
    parameter int FLD_W   = FLD_W_DEF,
    parameter int RTT_W   = RTT_W_DEF,
    parameter int BL4_CYC = BL4_CYC_DEF,
    parameter int BL8_CYC = BL8_CYC_DEF,
    localparam int CW     = cnt_width(max_off(FLD_W, RTT_W, BL8_CYC))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_cmd,
    input  logic             burst8,
    input  logic [FLD_W-1:0] en_a,
    input  logic [FLD_W-1:0] en_b,
    input  logic [FLD_W-1:0] dis_a,
    input  logic [FLD_W-1:0] dis_b,
    input  logic [RTT_W-1:0] rtt,
    output logic             rd_win,
    output logic             rd_busy
);
    logic [CW-1:0] base, e_sum, f_sum, cnt, on_pt, off_pt;
    logic          busy, hold;

    // Offset arithmetic, zero-extended so no sum can wrap
    always_comb begin
        base  = burst8 ? CW'(BL8_CYC) : CW'(BL4_CYC);
        e_sum = CW'(en_a) + CW'(en_b) + CW'(rtt);
        f_sum = CW'(rtt) + base + CW'(dis_a) + CW'(dis_b);
    end

    // Window is on between the near point and the far point, or while held
    assign rd_win  = busy && (hold || (cnt >= on_pt));
    assign rd_busy = busy;

    // Counter and captured offsets; a new read restarts the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            hold   <= 1'b0;
            cnt    <= '0;
            on_pt  <= '0;
            off_pt <= '0;
        end else if (rd_cmd) begin
            busy   <= 1'b1;
            hold   <= rd_win;
            cnt    <= '0;
            on_pt  <= e_sum;
            off_pt <= f_sum;
        end else if (busy) begin
            if (cnt + CW'(1) >= off_pt) begin
                busy <= 1'b0;
                hold <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // R2
    load_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |=> (busy && cnt == '0));
    // R3
    far_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_cmd && (cnt + CW'(1) >= off_pt)) |=> !busy);
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < off_pt));
    // R6
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && rd_win) |=> rd_win);
endmodule

// File: rtl/odt_write_win.sv
// Write termination window: open from k = 0 for base + tail cycles after a
// write. The pin-driving gate at the top removes the burst part of it.
module odt_write_win
    import odt_pkg::*;
#(
    parameter int FLD_W   = FLD_W_DEF,
    parameter int BL4_CYC = BL4_CYC_DEF,
    parameter int BL8_CYC = BL8_CYC_DEF,
    localparam int CW     = cnt_width(BL8_CYC + 2 ** FLD_W - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic             burst8,
    input  logic [FLD_W-1:0] tail,
    output logic             wr_win
);
    logic [CW-1:0] len_sum, len, cnt;
    logic          busy;

    // Window length: burst base plus the programmed tail
    assign len_sum = (burst8 ? CW'(BL8_CYC) : CW'(BL4_CYC)) + CW'(tail);
    assign wr_win  = busy;

    // Length capture and countdown; a new write restarts it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            len  <= '0;
        end else if (wr_cmd) begin
            busy <= 1'b1;
            cnt  <= '0;
            len  <= len_sum;
        end else if (busy) begin
            if (cnt + CW'(1) >= len) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // R7
    wr_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> busy);
    // R7
    wr_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_cmd && (cnt + CW'(1) >= len)) |=> !busy);
endmodule

// File: rtl/odt_timing_ctrl.sv
// Top of the termination timing controller. Combines the read and write
// windows with the static override, then forces the result off while the
// pins drive. Assumes command strobes last one cycle.
module odt_timing_ctrl
    import odt_pkg::*;
#(
    parameter int FLD_W   = FLD_W_DEF,
    parameter int RTT_W   = RTT_W_DEF,
    parameter int BL4_CYC = BL4_CYC_DEF,
    parameter int BL8_CYC = BL8_CYC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_cmd,
    input  logic             wr_cmd,
    input  logic             burst8,
    input  logic             bus_idle,
    input  logic             pins_driving,
    input  logic             override_en,
    input  logic [FLD_W-1:0] rd_en_a,
    input  logic [FLD_W-1:0] rd_en_b,
    input  logic [FLD_W-1:0] rd_dis_a,
    input  logic [FLD_W-1:0] rd_dis_b,
    input  logic [RTT_W-1:0] rtt_align,
    input  logic [FLD_W-1:0] wr_dis,
    output logic             odt_en
);
    logic rd_win, rd_busy, wr_win, ovr_on;

    odt_read_win #(
        .FLD_W(FLD_W), .RTT_W(RTT_W), .BL4_CYC(BL4_CYC), .BL8_CYC(BL8_CYC)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .burst8(burst8),
        .en_a(rd_en_a), .en_b(rd_en_b), .dis_a(rd_dis_a), .dis_b(rd_dis_b),
        .rtt(rtt_align), .rd_win(rd_win), .rd_busy(rd_busy)
    );

    odt_write_win #(
        .FLD_W(FLD_W), .BL4_CYC(BL4_CYC), .BL8_CYC(BL8_CYC)
    ) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .burst8(burst8),
        .tail(wr_dis), .wr_win(wr_win)
    );

    // Override holds termination through each read and while idle
    assign ovr_on = override_en && (rd_busy || bus_idle);

    // Final enable, gated off whenever the pins drive
    assign odt_en = !pins_driving && (rd_win || wr_win || ovr_on);

    // R8
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pins_driving |-> !odt_en);
    // R9
    idle_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (override_en && bus_idle && !pins_driving) |-> odt_en);
endmodule

// File: tb/sim_odt_timing_ctrl.sv
module sim_odt_timing_ctrl;
    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_cmd = 0, wr_cmd = 0, burst8 = 0, bus_idle = 0, pins_driving = 0, override_en = 0;
    logic [2:0] rd_en_a = 0, rd_en_b = 0, rd_dis_a = 0, rd_dis_b = 0, wr_dis = 0;
    logic [3:0] rtt_align = 0;
    logic odt_en;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    odt_timing_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .burst8(burst8),
        .bus_idle(bus_idle), .pins_driving(pins_driving), .override_en(override_en),
        .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .rd_dis_a(rd_dis_a), .rd_dis_b(rd_dis_b),
        .rtt_align(rtt_align), .wr_dis(wr_dis), .odt_en(odt_en)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s odt_en=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One read with the given fields; fields are scrambled after acceptance
    task automatic run_read(input int ea, input int eb, input int rt, input int da,
                            input int db, input int b8, input string force_tag);
        int e, f;
        string tag;
        e = ea + eb + rt;
        f = rt + (b8 ? 7 : 5) + da + db;
        @(negedge clk);
        rd_en_a = 3'(ea); rd_en_b = 3'(eb); rtt_align = 4'(rt);
        rd_dis_a = 3'(da); rd_dis_b = 3'(db); burst8 = b8[0]; rd_cmd = 1'b1;
        @(negedge clk);
        rd_cmd = 1'b0;
        rd_en_a = ~rd_en_a; rd_en_b = ~rd_en_b; rtt_align = ~rtt_align;
        rd_dis_a = ~rd_dis_a; rd_dis_b = ~rd_dis_b; burst8 = ~burst8;
        for (int k = 0; k < f + 2; k++) begin
            #5;
            if (force_tag != "") tag = force_tag;
            else if (e >= f) tag = "R10";
            else if (e > 15 || f > 31) tag = "R4";
            else if (k < e) tag = "R2";
            else tag = "R3";
            chk(tag, odt_en, ((k >= e && k < f) || (override_en && k < f)) ? 1'b1 : 1'b0);
            @(negedge clk);
        end
    endtask

    // One write with the pins driving during the burst
    task automatic run_write(input int wd, input int b8);
        int base;
        base = b8 ? 7 : 5;
        @(negedge clk);
        wr_dis = 3'(wd); burst8 = b8[0]; wr_cmd = 1'b1;
        @(negedge clk);
        wr_cmd = 1'b0; wr_dis = ~wr_dis;
        for (int k = 0; k < base + wd + 2; k++) begin
            pins_driving = (k < base);
            #5;
            chk(k < base ? "R8" : "R7", odt_en, (k >= base && k < base + wd) ? 1'b1 : 1'b0);
            @(negedge clk);
        end
        pins_driving = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run still active, expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        bus_idle = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5 chk("R1", odt_en, 1'b0);
        @(negedge clk); #5 chk("R1", odt_en, 1'b0);
        bus_idle = 1'b0;

        // R2 R3 R4 R10: sweep of offset fields, scrambled afterwards (R5)
        for (int a = 0; a < 8; a++)
            for (int bi = 0; bi < 3; bi++)
                for (int ri = 0; ri < 3; ri++)
                    for (int da = 0; da < 8; da += 7)
                        for (int db = 0; db < 8; db += 7)
                            for (int b8 = 0; b8 < 2; b8++)
                                run_read(a, (bi == 0) ? 0 : (bi == 1) ? 3 : 7,
                                         (ri == 0) ? 0 : (ri == 1) ? 5 : 15, da, db, b8, "");

        // R5: directed case, fields changed to maximum mid-window
        run_read(2, 0, 0, 0, 0, 0, "R5");

        // R6: back-to-back read while the window is on
        @(negedge clk);
        rd_en_a = 3'd3; rd_en_b = 0; rtt_align = 0; rd_dis_a = 0; rd_dis_b = 0;
        burst8 = 0; rd_cmd = 1'b1;
        @(negedge clk); rd_cmd = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #5 chk("R6", odt_en, 1'b0);
            @(negedge clk);
        end
        rd_cmd = 1'b1;
        #5 chk("R6", odt_en, 1'b1);
        @(negedge clk); rd_cmd = 1'b0;
        for (int k = 0; k < 7; k++) begin
            #5 chk("R6", odt_en, (k < 5) ? 1'b1 : 1'b0);
            @(negedge clk);
        end

        // R8: pins driving in the middle of a read window
        rd_en_a = 0; rd_cmd = 1'b1;
        @(negedge clk); rd_cmd = 1'b0;
        for (int k = 0; k < 6; k++) begin
            pins_driving = (k == 2);
            #5 chk("R8", odt_en, (k < 5 && k != 2) ? 1'b1 : 1'b0);
            @(negedge clk);
        end
        pins_driving = 1'b0;

        // R7 R8: writes with every tail length
        for (int wd = 0; wd < 8; wd++)
            for (int b8 = 0; b8 < 2; b8++)
                run_write(wd, b8);

        // R9: override while idle, while driving, and across a read
        @(negedge clk);
        override_en = 1'b1; bus_idle = 1'b1;
        #5 chk("R9", odt_en, 1'b1);
        @(negedge clk); pins_driving = 1'b1;
        #5 chk("R9", odt_en, 1'b0);
        @(negedge clk); pins_driving = 1'b0; bus_idle = 1'b0;
        #5 chk("R9", odt_en, 1'b0);
        run_read(7, 7, 0, 0, 0, 0, "R9");
        run_read(0, 0, 2, 0, 0, 1, "R9");
        override_en = 1'b0;
        @(negedge clk); #5 chk("R9", odt_en, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule